// File: doc/BRIEF.md
# EPROM Control-Mode Decoder and Signature Responder

This block is a synthesizable behavioural model of the control side of a one-time-programmable byte-wide memory. Each cycle it samples the active-low chip enable and output enable, a flag that reports high voltage on the programming supply pin, and a flag that reports high voltage on the identification address pin. From these it picks one of eight operating modes. The mode decides whether the 8-bit data bus is driven, what is driven onto it, and whether a programming pulse is in progress.

The storage is a small array that starts as all ones. A program pulse can only clear bits: the stored byte becomes the old byte AND the new byte. A pulse is accepted on the rising edge of chip enable, and only if the low period lasted at least a set number of cycles. A pulse that is too short is dropped and counted. An identification mode returns a maker byte or a device byte chosen by the lowest address bit. Supply-flag combinations that have no meaning float the bus and raise an error flag.

The model is meant as a self-checking target for a programming sequencer or a read controller. It is not meant for silicon timing.

Top module: `lvp_prom_ctrl`

## Requirements
- R1: After reset every cell reads FFh and the short-pulse count is 0.
- R2: With both enables low and both voltage flags clear (read), dq_oe is 1 and dq_out equals the cell at addr.
- R3: With both voltage flags clear, chip enable high (standby) or output enable high (output disable) gives dq_oe = 0, whatever the other enable does.
- R4: With the programming-voltage flag set, the identification flag clear, chip enable low and output enable high (program), dq_oe is 0 and dq_in is taken as the byte to write.
- R5: A program low period of at least MIN_PW consecutive sampled cycles, ended by chip enable sampled high, sets the cell at the last captured address to (old AND data). A bit that is 0 never returns to 1.
- R6: A program low period shorter than MIN_PW cycles leaves the array unchanged and raises short_cnt by one, holding at its maximum value. A low period interrupted by leaving program mode before chip enable rises neither writes nor counts.
- R7: With the programming-voltage flag set, chip enable high and output enable low (verify), dq_oe is 1 and dq_out equals the cell at addr.
- R8: With the programming-voltage flag set and both enables high (inhibit), dq_oe is 0.
- R9: With the identification flag set, the programming-voltage flag clear, both enables low and addr[AW-1:1] zero, dq_out is 20h when addr[0] is 0 and B4h when addr[0] is 1, with dq_oe = 1 and id_invalid = 0.
- R10: In the identification mode with any of addr[AW-1:1] nonzero, dq_out is FFh, dq_oe is 1 and id_invalid is 1. Outside that mode id_invalid is 0.
- R11: Both voltage flags set, or the programming-voltage flag set with both enables low, is illegal: dq_oe is 0 and combo_err is 1. combo_err is 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply at high voltage |
| id_hv | input | 1 | Identification address pin at high voltage |
| addr | input | AW | Byte address |
| dq_in | input | 8 | Data bus as seen by the block (program data) |
| dq_out | output | 8 | Data the block drives onto the bus |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |
| id_invalid | output | 1 | Identification access with nonzero upper address bits |
| combo_err | output | 1 | Illegal combination of control and voltage flags |
| short_cnt | output | CW | Saturating count of rejected short program pulses |

## Verification
The hardest cases to reach are at the edge of pulse qualification. These are a low period of exactly MIN_PW cycles against one of MIN_PW-1 cycles, and a low period cut short by a mode change before chip enable rises. Only the effect on a later verify read or on short_cnt shows which case happened. Directed pulses of both lengths are therefore followed by verify reads of the same cell. Random segments hold one control pattern for one to eight cycles, so program pulses of many lengths occur naturally and get broken up by illegal or inhibit patterns. A bench model of the array and pulse rules predicts every bus value.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  typedef enum logic [2:0] {
    M_READ    = 3'd0,
    M_ODIS    = 3'd1,
    M_PROG    = 3'd2,
    M_VERIFY  = 3'd3,
    M_INHIBIT = 3'd4,
    M_STBY    = 3'd5,
    M_IDENT   = 3'd6,
    M_ILLEGAL = 3'd7
  } mode_t;
endpackage

// File: rtl/lvp_mode_decode.sv
module lvp_mode_decode
  import lvp_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  id_hv,
  output mode_t mode
);
  always_comb begin
    if (vpp_hi && id_hv) begin
      mode = M_ILLEGAL;
    end else if (vpp_hi) begin
      case ({ce_n, oe_n})
        2'b01:   mode = M_PROG;
        2'b10:   mode = M_VERIFY;
        2'b11:   mode = M_INHIBIT;
        default: mode = M_ILLEGAL;
      endcase
    end else if (ce_n) begin
      mode = M_STBY;
    end else if (oe_n) begin
      mode = M_ODIS;
    end else if (id_hv) begin
      mode = M_IDENT;
    end else begin
      mode = M_READ;
    end
  end
endmodule

// File: rtl/lvp_pulse_qual.sv
module lvp_pulse_qual #(
  parameter int AW     = 6,
  parameter int DW     = 8,
  parameter int MIN_PW = 4,
  parameter int CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_prog,
  input  logic          ce_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [CW-1:0] short_cnt
);
  localparam int RW = $clog2(MIN_PW + 1);
  localparam logic [RW-1:0] RUN_SAT = RW'(MIN_PW);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [RW-1:0] run_q, run_d;
  logic          armed_q, armed_d;
  logic [AW-1:0] la_q, la_d;
  logic [DW-1:0] ld_q, ld_d;
  logic [CW-1:0] sc_q, sc_d;
  logic          pulse_end, long_enough;

  assign pulse_end   = armed_q && ce_n;
  assign long_enough = (run_q >= RUN_SAT);

  always_comb begin
    run_d   = '0;
    armed_d = 1'b0;
    la_d    = la_q;
    ld_d    = ld_q;
    sc_d    = sc_q;
    if (in_prog) begin
      armed_d = 1'b1;
      run_d   = (run_q == RUN_SAT) ? run_q : run_q + 1'b1;
      la_d    = addr;
      ld_d    = din;
    end
    if (pulse_end && !long_enough && (sc_q != CNT_MAX)) begin
      sc_d = sc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
      la_q    <= '0;
      ld_q    <= '0;
      sc_q    <= '0;
    end else begin
      run_q   <= run_d;
      armed_q <= armed_d;
      la_q    <= la_d;
      ld_q    <= ld_d;
      sc_q    <= sc_d;
    end
  end

  assign wr_en     = pulse_end && long_enough;
  assign wr_addr   = la_q;
  assign wr_data   = ld_q;
  assign short_cnt = sc_q;

  // R6: the rejected-pulse count never decreases
  a_r6_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> short_cnt >= $past(short_cnt));
  // R6: a write and a rejection never coincide with an unchanged count rule broken
  a_r6_no_count_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(short_cnt));
endmodule

// File: rtl/lvp_cell_array.sv
module lvp_cell_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];
  logic [DW-1:0] wr_old;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic          hit;
    logic [DW-1:0] nxt;
    assign hit = wr_en && (wr_addr == AW'(g));
    assign nxt = hit ? (cell_q[g] & wr_data) : cell_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q[g] <= {DW{1'b1}};
      else if (hit) cell_q[g] <= nxt;
    end
  end

  assign rd_data = cell_q[rd_addr];
  assign wr_old  = cell_q[wr_addr];

  // R5: a program pulse leaves old AND data in the addressed cell
  a_r5_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cell_q[$past(wr_addr)] == ($past(wr_old) & $past(wr_data)));
endmodule

// File: rtl/lvp_prom_ctrl.sv
module lvp_prom_ctrl
  import lvp_pkg::*;
#(
  parameter int          AW      = 6,
  parameter int          MIN_PW  = 4,
  parameter int          CW      = 8,
  parameter logic [7:0]  MAKER_B = 8'h20,
  parameter logic [7:0]  DEV_B   = 8'hB4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hi,
  input  logic          id_hv,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_in,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  output logic          id_invalid,
  output logic          combo_err,
  output logic [CW-1:0] short_cnt
);
  localparam int DW = 8;

  logic          rs_q1, rs_q2;
  mode_t         mode;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic          id_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  lvp_mode_decode u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .id_hv  (id_hv),
    .mode   (mode)
  );

  lvp_pulse_qual #(.AW(AW), .DW(DW), .MIN_PW(MIN_PW), .CW(CW)) u_pq (
    .clk       (clk),
    .rst_n     (rs_q2),
    .in_prog   (mode == M_PROG),
    .ce_n      (ce_n),
    .addr      (addr),
    .din       (dq_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .short_cnt (short_cnt)
  );

  lvp_cell_array #(.AW(AW), .DW(DW)) u_arr (
    .clk     (clk),
    .rst_n   (rs_q2),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (rd_data)
  );

  assign id_bad = |addr[AW-1:1];

  always_comb begin
    dq_oe      = 1'b0;
    dq_out     = '0;
    id_invalid = 1'b0;
    combo_err  = (mode == M_ILLEGAL);
    case (mode)
      M_READ, M_VERIFY: begin
        dq_oe  = 1'b1;
        dq_out = rd_data;
      end
      M_IDENT: begin
        dq_oe      = 1'b1;
        id_invalid = id_bad;
        dq_out     = id_bad ? 8'hFF : (addr[0] ? DEV_B : MAKER_B);
      end
      default: ;
    endcase
  end

  // R3: no drive when deselected without programming voltage
  a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rs_q2)
    (ce_n && !vpp_hi) |-> !dq_oe);
  // R4: bus is an input during a program pulse
  a_r4_prog_input: assert property (@(posedge clk) disable iff (!rs_q2)
    (vpp_hi && !id_hv && !ce_n && oe_n) |-> !dq_oe);
  // R10: an invalid identification access returns all ones
  a_r10_invalid_ff: assert property (@(posedge clk) disable iff (!rs_q2)
    id_invalid |-> (dq_oe && dq_out == 8'hFF));
  // R11: an illegal combination never drives the bus
  a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rs_q2)
    combo_err |-> !dq_oe);
  // R11: both high-voltage flags always count as illegal
  a_r11_both_flags: assert property (@(posedge clk) disable iff (!rs_q2)
    (vpp_hi && id_hv) |-> combo_err);
endmodule

// File: tb/lvp_prom_ctrl_tb.sv
module lvp_prom_ctrl_tb_top;
  localparam int AW     = 6;
  localparam int DEPTH  = 1 << AW;
  localparam int MIN_PW = 4;
  localparam int CW     = 8;
  localparam int WD_NS  = 4 * 150000;

  logic          clk;
  logic          rst_n;
  logic          ce_n, oe_n, vpp_hi, id_hv;
  logic [AW-1:0] addr;
  logic [7:0]    dq_in;
  logic [7:0]    dq_out;
  logic          dq_oe, id_invalid, combo_err;
  logic [CW-1:0] short_cnt;

  lvp_prom_ctrl #(.AW(AW), .MIN_PW(MIN_PW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hv(id_hv), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .id_invalid(id_invalid), .combo_err(combo_err),
    .short_cnt(short_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [7:0]    ref_mem [DEPTH];
  int            ref_run;
  bit            ref_armed;
  logic [AW-1:0] ref_la;
  logic [7:0]    ref_ld;
  int            ref_short;

  // 0 read,1 odis,2 prog,3 verify,4 inhibit,5 standby,6 ident,7 illegal
  function automatic int bdecode(logic c, logic o, logic v, logic i);
    if (v && i) return 7;
    if (v) begin
      if (!c && o) return 2;
      if (c && !o) return 3;
      if (c && o) return 4;
      return 7;
    end
    if (c) return 5;
    if (o) return 1;
    if (i) return 6;
    return 0;
  endfunction

  function automatic string tag_of(int m);
    case (m)
      0: return "R2";
      1, 5: return "R3";
      2: return "R4";
      3: return "R7";
      4: return "R8";
      6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic c, logic o, logic v, logic i,
                      logic [AW-1:0] a, logic [7:0] d);
    int m;
    logic exp_oe, exp_inv, exp_err;
    logic [7:0] exp_out;
    string tg;
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; id_hv = i; addr = a; dq_in = d;
    #1;
    m = bdecode(c, o, v, i);
    tg = tag_of(m);
    exp_oe = (m == 0 || m == 3 || m == 6);
    exp_inv = (m == 6) && (a[AW-1:1] != '0);
    exp_err = (m == 7);
    if (m == 6) begin
      exp_out = exp_inv ? 8'hFF : (a[0] ? 8'hB4 : 8'h20);
      if (exp_inv) tg = "R10";
    end else begin
      exp_out = ref_mem[a];
    end
    chk(tg, dq_oe, exp_oe);
    if (exp_oe) chk(tg, dq_out, exp_out);
    chk("R10", id_invalid, exp_inv);
    chk("R11", combo_err, exp_err);
    chk("R6", short_cnt, ref_short);
    // model of the coming clock edge
    if (ref_armed && c) begin
      if (ref_run >= MIN_PW) ref_mem[ref_la] = ref_mem[ref_la] & ref_ld;
      else if (ref_short < (1 << CW) - 1) ref_short++;
    end
    if (m == 2) begin
      ref_armed = 1'b1;
      if (ref_run < MIN_PW) ref_run++;
      ref_la = a;
      ref_ld = d;
    end else begin
      ref_armed = 1'b0;
      ref_run = 0;
    end
  endtask

  task automatic pulse(logic [AW-1:0] a, logic [7:0] d, int len);
    for (int k = 0; k < len; k++) step(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    step(1'b1, 1'b1, 1'b1, 1'b0, a, 8'h00);
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1F2E);
    for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
    ref_run = 0; ref_armed = 1'b0; ref_la = '0; ref_ld = '0; ref_short = 0;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b0;
    addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset contents and counter
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, AW'(k * 17), 8'h00);
      chk("R1", dq_out, 8'hFF);
    end
    chk("R1", short_cnt, 0);

    // R3 / R4 / R8 quiet modes
    step(1'b1, 1'b0, 1'b0, 1'b0, 6'd1, 8'h00);
    step(1'b0, 1'b1, 1'b0, 1'b0, 6'd1, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b0, 6'd1, 8'h00);

    // R5: exact-length pulse writes, then bits only clear
    pulse(6'd5, 8'h3C, MIN_PW);
    step(1'b1, 1'b0, 1'b1, 1'b0, 6'd5, 8'h00);
    chk("R5", dq_out, 8'h3C);
    pulse(6'd5, 8'hF0, MIN_PW + 2);
    step(1'b1, 1'b0, 1'b1, 1'b0, 6'd5, 8'h00);
    chk("R5", dq_out, 8'h30);
    pulse(6'd5, 8'hFF, MIN_PW);
    step(1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00);
    chk("R5", dq_out, 8'h30);

    // R6: one cycle short is rejected and counted
    pulse(6'd6, 8'h00, MIN_PW - 1);
    step(1'b1, 1'b0, 1'b1, 1'b0, 6'd6, 8'h00);
    chk("R6", dq_out, 8'hFF);
    chk("R6", short_cnt, 1);
    // R6: interrupted low period neither writes nor counts
    for (int k = 0; k < MIN_PW + 1; k++) step(1'b0, 1'b1, 1'b1, 1'b0, 6'd7, 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b0, 6'd7, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b0, 6'd7, 8'h00);
    step(1'b1, 1'b0, 1'b1, 1'b0, 6'd7, 8'h00);
    chk("R6", dq_out, 8'hFF);
    chk("R6", short_cnt, 1);

    // R9 / R10: identification bytes
    step(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 8'h00);
    chk("R9", dq_out, 8'h20);
    step(1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 8'h00);
    chk("R9", dq_out, 8'hB4);
    step(1'b0, 1'b0, 1'b0, 1'b1, 6'd33, 8'h00);
    chk("R10", id_invalid, 1'b1);

    // R11: illegal combinations
    step(1'b0, 1'b1, 1'b1, 1'b1, 6'd0, 8'h00);
    chk("R11", combo_err, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 8'h00);
    chk("R11", dq_oe, 1'b0);

    // random segments
    for (int s = 0; s < 400; s++) begin
      logic c, o, v, i;
      logic [AW-1:0] a;
      logic [7:0] d;
      int len;
      int pick;
      pick = $urandom % 10;
      c = $urandom % 2; o = $urandom % 2;
      v = (pick < 5); i = (pick == 9) || (pick == 4);
      if (pick < 3) begin c = 1'b0; o = 1'b1; i = 1'b0; end
      a = AW'($urandom);
      if ($urandom % 2) a[AW-1:1] = '0;
      d = 8'($urandom);
      len = 1 + ($urandom % 8);
      for (int k = 0; k < len; k++) step(c, o, v, i, a, d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule